// File: doc/BRIEF.md
# Revertive Clock Source Selector

This block chooses which timing source drives a node's system clock. There are three candidates: a primary reference, a secondary reference and an internal free-running oscillator. Each reference comes with four health flags from its line interface: loss of signal, alarm indication signal, out-of-frame and frequency-out-of-tolerance. A monitor for each reference turns these flags into a qualified "usable" indication. It also raises a one-cycle alarm whenever a fault begins, whether that reference is carrying traffic or standing by.

A state machine picks the source from these indications. It switches to the other reference when the active one fails. It falls back to free-run when both references are unusable, and it obeys user-forced switchovers. When the primary is left, the machine records why. A signal-class fault (loss of signal, AIS, out-of-frame) always permits a later return to the primary. A fault caused only by frequency drift permits that return only when a drift-revert configuration bit is set. Every change of source is sent to an external glitch-free clock mux as a one-cycle request. The change is then held until the mux reports completion.

Top module: `clk_src_selector`

## Requirements
- R1: A reference is faulty while any of its four status bits is set. In each 4-bit status port, bit 0 is loss of signal, bit 1 is AIS, bit 2 is out-of-frame and bit 3 is frequency fault. A faulty reference is never kept as, or switched to, the active source.
- R2: When the active reference becomes faulty, the selector moves to the other reference if that reference is usable, and otherwise to free-run. The `sel_code` values are 00 for primary, 01 for secondary and 10 for free-run.
- R3: Free-run (code 10) is entered only when neither reference is usable. From free-run, the selector moves to the primary if it is usable, and otherwise to the secondary.
- R4: After a fault clears, a reference becomes usable only once it has been fault-free for HOLDOFF consecutive clock edges. The selector can switch to it on the next edge after that.
- R5: When revertive mode is on (`cfg_revertive`=1) and the primary was left because of a signal-class fault, the selector returns from secondary to primary once the primary is usable again.
- R6: When the primary was left because of a frequency fault alone, a later return depends on `cfg_drift_revert` as sampled at the moment of leaving. With 0 the selector stays on the secondary; with 1 it reverts.
- R7: When `cfg_revertive`=0, the selector stays on the secondary after the primary recovers.
- R8: At the onset of a fault on either reference, whether active or standby, the matching alarm output is high for exactly one cycle.
- R9: A `force_req` pulse moves to the target given by `force_to_sec` (1 = secondary, 0 = primary) only if that target is usable. A forced move away from the primary blocks automatic reversion until the next move. A force towards an unusable target causes no change and no request.
- R10: Every change of `sel_code` comes with a one-cycle `sel_req` pulse and raises `sel_busy`. `sel_busy` stays high until `mux_done` is sampled, and `sel_code` does not change while `sel_busy` is high.
- R11: In reset, `sel_code` is 10 (free-run), and `sel_req`, `sel_busy` and both alarms are low. Both references start unqualified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_status | input | 4 | Primary health flags {freq, oof, ais, los} |
| sec_status | input | 4 | Secondary health flags {freq, oof, ais, los} |
| cfg_revertive | input | 1 | 1 enables automatic return to primary |
| cfg_drift_revert | input | 1 | 1 lets a drift-only primary exit revert |
| force_req | input | 1 | One-cycle user switchover command |
| force_to_sec | input | 1 | Force target: 1 secondary, 0 primary |
| mux_done | input | 1 | Clock mux reports switch complete |
| sel_code | output | 2 | Selected source: 00 pri, 01 sec, 10 free-run |
| sel_req | output | 1 | One-cycle pulse on each source change |
| sel_busy | output | 1 | Switch in progress, awaiting mux_done |
| alarm_pri | output | 1 | One-cycle pulse on primary fault onset |
| alarm_sec | output | 1 | One-cycle pulse on secondary fault onset |

## Verification
The assertions check the following on every cycle. Each request lasts one cycle, and the code stays stable while a switch awaits its completion. No code change happens without a request. Free-run is entered only after both references were unusable, alarms never last more than one cycle, and a fault always removes a reference's usability on the next cycle. Whether the selector reverts or stays put depends on the history of why the primary was left, which configuration applied at that moment, and whether the move was forced. Only the bench's scenario sequences can show that. The same holds for the exact edge where the hold-off expires.

// File: rtl/clk_sel_pkg.sv
package clk_sel_pkg;

    localparam int NUM_REF = 2;
    localparam int REF_PRI = 0;
    localparam int REF_SEC = 1;

    typedef enum logic [1:0] {
        SRC_PRI  = 2'b00,
        SRC_SEC  = 2'b01,
        SRC_FREE = 2'b10
    } src_e;

    typedef struct packed {
        logic freq;
        logic oof;
        logic ais;
        logic los;
    } ref_health_t;

    function automatic logic any_fault(ref_health_t h);
        return h.freq | h.oof | h.ais | h.los;
    endfunction

    function automatic logic signal_fault(ref_health_t h);
        return h.oof | h.ais | h.los;
    endfunction

endpackage

// File: rtl/clk_ref_monitor.sv
module clk_ref_monitor
    import clk_sel_pkg::*;
#(
    parameter int HOLDOFF = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  ref_health_t health,
    output logic        usable,
    output logic        sig_class,
    output logic        alarm
);
    localparam int CNT_W = $clog2(HOLDOFF + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HOLDOFF);

    logic [CNT_W-1:0] clean_cnt;
    logic             fault_now;
    logic             fault_prev;

    assign fault_now = any_fault(health);
    assign sig_class = signal_fault(health);
    assign usable    = !fault_now && (clean_cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            clean_cnt  <= '0;
            fault_prev <= 1'b0;
            alarm      <= 1'b0;
        end else begin
            fault_prev <= fault_now;
            alarm      <= fault_now && !fault_prev;
            if (fault_now)
                clean_cnt <= '0;
            else if (clean_cnt != CNT_MAX)
                clean_cnt <= clean_cnt + 1'b1;
        end
    end

    // R8: an alarm never lasts more than one cycle
    p_alarm_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        alarm |=> !alarm);

    // R4: a fault leaves the reference unusable on the following cycle
    p_fault_unqualifies_r4: assert property (@(posedge clk) disable iff (rst)
        fault_now |=> !usable);

endmodule

// File: rtl/clk_sel_fsm.sv
module clk_sel_fsm
    import clk_sel_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pri_ok,
    input  logic sec_ok,
    input  logic pri_sig_fault,
    input  logic cfg_revertive,
    input  logic cfg_drift_revert,
    input  logic force_req,
    input  logic force_to_sec,
    input  logic mux_done,
    output src_e cur_src,
    output logic req,
    output logic busy
);
    src_e nxt_src;
    logic revert_ok;
    logic revert_ok_nxt;

    always_comb begin
        nxt_src       = cur_src;
        revert_ok_nxt = revert_ok;
        unique case (cur_src)
            SRC_PRI: begin
                if (!pri_ok) begin
                    nxt_src       = sec_ok ? SRC_SEC : SRC_FREE;
                    revert_ok_nxt = pri_sig_fault | cfg_drift_revert;
                end else if (force_req && force_to_sec && sec_ok) begin
                    nxt_src       = SRC_SEC;
                    revert_ok_nxt = 1'b0;
                end
            end
            SRC_SEC: begin
                if (!sec_ok)
                    nxt_src = pri_ok ? SRC_PRI : SRC_FREE;
                else if (pri_ok && ((force_req && !force_to_sec) ||
                                    (cfg_revertive && revert_ok)))
                    nxt_src = SRC_PRI;
            end
            default: begin
                if (pri_ok)
                    nxt_src = SRC_PRI;
                else if (sec_ok)
                    nxt_src = SRC_SEC;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_src   <= SRC_FREE;
            req       <= 1'b0;
            busy      <= 1'b0;
            revert_ok <= 1'b1;
        end else begin
            req <= 1'b0;
            if (busy) begin
                if (mux_done)
                    busy <= 1'b0;
            end else if (nxt_src != cur_src) begin
                cur_src   <= nxt_src;
                req       <= 1'b1;
                busy      <= 1'b1;
                revert_ok <= revert_ok_nxt;
            end
        end
    end

    // R10: request is a single-cycle pulse
    p_req_single_r10: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);

    // R10: no source change while waiting for the mux
    p_hold_while_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !mux_done) |=> $stable(cur_src));

    // R10: every source change is announced
    p_change_has_req_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_src) |-> req);

    // R3: free-run is entered only when neither reference was usable
    p_free_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (cur_src == SRC_FREE && $past(cur_src) != SRC_FREE) |-> $past(!pri_ok && !sec_ok));

endmodule

// File: rtl/clk_src_selector.sv
module clk_src_selector
    import clk_sel_pkg::*;
#(
    parameter int HOLDOFF = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] pri_status,
    input  logic [3:0] sec_status,
    input  logic       cfg_revertive,
    input  logic       cfg_drift_revert,
    input  logic       force_req,
    input  logic       force_to_sec,
    input  logic       mux_done,
    output logic [1:0] sel_code,
    output logic       sel_req,
    output logic       sel_busy,
    output logic       alarm_pri,
    output logic       alarm_sec
);
    ref_health_t        health [NUM_REF];
    logic [NUM_REF-1:0] ref_ok;
    logic [NUM_REF-1:0] ref_sig;
    logic [NUM_REF-1:0] ref_alarm;
    src_e               cur_src;

    assign health[REF_PRI] = ref_health_t'(pri_status);
    assign health[REF_SEC] = ref_health_t'(sec_status);

    for (genvar g = 0; g < NUM_REF; g++) begin : g_mon
        clk_ref_monitor #(.HOLDOFF(HOLDOFF)) u_mon (
            .clk       (clk),
            .rst       (rst),
            .health    (health[g]),
            .usable    (ref_ok[g]),
            .sig_class (ref_sig[g]),
            .alarm     (ref_alarm[g])
        );
    end

    clk_sel_fsm u_fsm (
        .clk              (clk),
        .rst              (rst),
        .pri_ok           (ref_ok[REF_PRI]),
        .sec_ok           (ref_ok[REF_SEC]),
        .pri_sig_fault    (ref_sig[REF_PRI]),
        .cfg_revertive    (cfg_revertive),
        .cfg_drift_revert (cfg_drift_revert),
        .force_req        (force_req),
        .force_to_sec     (force_to_sec),
        .mux_done         (mux_done),
        .cur_src          (cur_src),
        .req              (sel_req),
        .busy             (sel_busy)
    );

    assign sel_code  = cur_src;
    assign alarm_pri = ref_alarm[REF_PRI];
    assign alarm_sec = ref_alarm[REF_SEC];

    // R1: a faulty reference is never the source after a settled cycle
    p_no_faulty_pri_r1: assert property (@(posedge clk) disable iff (rst)
        (|pri_status && !sel_busy && !sel_req) |=> (sel_code != 2'b00) || sel_req || $past(sel_busy));

endmodule

// File: tb/clk_src_selector_bench.sv
module clk_src_selector_bench;
    localparam int CLK_NS = 20;
    localparam int HOLD   = 3;
    localparam int SETTLE = 12;
    localparam int NVEC   = 16;

    // {pri[3:0], sec[3:0], revertive, drift, exp_sel[1:0]}
    localparam logic [11:0] VEC [NVEC] = '{
        {4'b0000, 4'b0000, 1'b1, 1'b0, 2'b00},
        {4'b0001, 4'b0000, 1'b1, 1'b0, 2'b01},
        {4'b0000, 4'b0000, 1'b1, 1'b0, 2'b00},
        {4'b1000, 4'b0000, 1'b1, 1'b0, 2'b01},
        {4'b0000, 4'b0000, 1'b1, 1'b0, 2'b01},
        {4'b0000, 4'b0001, 1'b1, 1'b0, 2'b00},
        {4'b0000, 4'b0000, 1'b1, 1'b1, 2'b00},
        {4'b1000, 4'b0000, 1'b1, 1'b1, 2'b01},
        {4'b0000, 4'b0000, 1'b1, 1'b1, 2'b00},
        {4'b0100, 4'b0000, 1'b1, 1'b0, 2'b01},
        {4'b0000, 4'b0000, 1'b1, 1'b0, 2'b00},
        {4'b0001, 4'b0010, 1'b1, 1'b0, 2'b10},
        {4'b0001, 4'b0000, 1'b1, 1'b0, 2'b01},
        {4'b0000, 4'b0000, 1'b0, 1'b0, 2'b01},
        {4'b0000, 4'b0001, 1'b0, 1'b0, 2'b00},
        {4'b0000, 4'b0000, 1'b1, 1'b0, 2'b00}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] pri_status, sec_status;
    logic       cfg_revertive, cfg_drift_revert;
    logic       force_req, force_to_sec, mux_done;
    logic [1:0] sel_code;
    logic       sel_req, sel_busy, alarm_pri, alarm_sec;

    int  checks = 0;
    int  failures = 0;
    int  req_cnt = 0;
    bit  auto_ack = 1'b1;
    bit  finished = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    clk_src_selector #(.HOLDOFF(HOLD)) u_clk_src_selector (
        .clk(clk), .rst(rst),
        .pri_status(pri_status), .sec_status(sec_status),
        .cfg_revertive(cfg_revertive), .cfg_drift_revert(cfg_drift_revert),
        .force_req(force_req), .force_to_sec(force_to_sec), .mux_done(mux_done),
        .sel_code(sel_code), .sel_req(sel_req), .sel_busy(sel_busy),
        .alarm_pri(alarm_pri), .alarm_sec(alarm_sec)
    );

    task automatic tick();
        @(posedge clk);
        #1;
        mux_done = auto_ack && sel_req;
        if (sel_req) req_cnt++;
    endtask

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic string vec_tag(int i);
        case (i)
            0: return "R3 startup prefers primary";
            1: return "R2 los failover";
            2: return "R5 revert after los";
            3: return "R1 freq fault failover";
            4: return "R6 drift no revert";
            5: return "R2 secondary fails to primary";
            6: return "R4 standby recovers quietly";
            7: return "R1 freq fault drift-revert set";
            8: return "R6 drift revert enabled";
            9: return "R1 oof failover";
            10: return "R5 revert after oof";
            11: return "R3 both fail to free-run";
            12: return "R3 free-run to secondary";
            13: return "R7 non-revertive stays";
            14: return "R2 secondary fails non-revertive";
            default: return "R5 final";
        endcase
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int snap;
        rst = 1'b1;
        pri_status = '0; sec_status = '0;
        cfg_revertive = 1'b1; cfg_drift_revert = 1'b0;
        force_req = 1'b0; force_to_sec = 1'b0; mux_done = 1'b0;
        wait_n(3);
        // R11: reset state
        check(sel_code == 2'b10, "R11 reset sel_code", sel_code, 2);
        check(!sel_req && !sel_busy, "R11 reset req/busy", {sel_req, sel_busy}, 0);
        check(!alarm_pri && !alarm_sec, "R11 reset alarms", {alarm_pri, alarm_sec}, 0);
        rst = 1'b0;
        // R4: hold-off after reset
        wait_n(HOLD);
        check(sel_code == 2'b10, "R4 still free-run during hold-off", sel_code, 2);
        tick();
        check(sel_code == 2'b00, "R4 primary after hold-off", sel_code, 0);
        check(sel_req == 1'b1, "R10 request pulse on change", sel_req, 1);
        tick();
        check(!sel_req && !sel_busy, "R10 pulse ends and ack clears busy", {sel_req, sel_busy}, 0);

        for (int v = 0; v < NVEC; v++) begin
            pri_status       = VEC[v][11:8];
            sec_status       = VEC[v][7:4];
            cfg_revertive    = VEC[v][3];
            cfg_drift_revert = VEC[v][2];
            wait_n(SETTLE);
            check(sel_code == VEC[v][1:0] && !sel_busy, vec_tag(v), sel_code, VEC[v][1:0]);
        end

        // R8: standby alarm
        sec_status = 4'b0001;
        tick();
        check(alarm_sec && !alarm_pri, "R8 standby alarm raised", {alarm_pri, alarm_sec}, 1);
        tick();
        check(!alarm_sec, "R8 alarm lasts one cycle", alarm_sec, 0);
        check(sel_code == 2'b00, "R8 standby fault keeps primary", sel_code, 0);
        sec_status = 4'b0000;
        wait_n(SETTLE);

        // R4: hold-off before reversion
        pri_status = 4'b0001;
        tick();
        check(alarm_pri, "R8 active alarm raised", alarm_pri, 1);
        wait_n(SETTLE);
        pri_status = 4'b0000;
        wait_n(HOLD);
        check(sel_code == 2'b01, "R4 no revert before hold-off", sel_code, 1);
        tick();
        check(sel_code == 2'b00, "R4 revert right after hold-off", sel_code, 0);
        wait_n(SETTLE);

        // R9: forced switchover
        force_req = 1'b1; force_to_sec = 1'b1;
        tick();
        force_req = 1'b0;
        check(sel_code == 2'b01, "R9 forced to secondary", sel_code, 1);
        wait_n(SETTLE);
        check(sel_code == 2'b01, "R9 forced exit blocks revert", sel_code, 1);
        force_req = 1'b1; force_to_sec = 1'b0;
        tick();
        force_req = 1'b0;
        check(sel_code == 2'b00, "R9 forced back to primary", sel_code, 0);
        wait_n(SETTLE);
        sec_status = 4'b0100;
        wait_n(SETTLE);
        snap = req_cnt;
        force_req = 1'b1; force_to_sec = 1'b1;
        tick();
        force_req = 1'b0;
        wait_n(4);
        check(sel_code == 2'b00, "R9 force to unusable target ignored", sel_code, 0);
        check(req_cnt == snap, "R9 no request from ignored force", req_cnt, snap);
        sec_status = 4'b0000;
        wait_n(SETTLE);

        // R10: handshake holds a second switch
        auto_ack = 1'b0;
        pri_status = 4'b0001;
        tick();
        check(sel_code == 2'b01 && sel_req && sel_busy, "R10 switch issued", {sel_code, sel_req, sel_busy}, 7);
        sec_status = 4'b0001;
        wait_n(6);
        check(sel_code == 2'b01 && sel_busy, "R10 held while busy", {sel_code, sel_busy}, 3);
        mux_done = 1'b1;
        tick();
        check(!sel_busy, "R10 busy cleared by mux_done", sel_busy, 0);
        auto_ack = 1'b1;
        tick();
        check(sel_code == 2'b10, "R3 free-run after held switch", sel_code, 2);
        pri_status = 4'b0000; sec_status = 4'b0000;
        wait_n(SETTLE);
        check(sel_code == 2'b00 && !sel_busy, "R3 primary after free-run", sel_code, 0);

        finish_run();
    end
endmodule